// File: doc/BRIEF.md
# Timer Channel Counter with Selectable Clock and Clear

This block is the counting core of one timer channel. A single 8-bit control register sets three things: where count pulses come from, which clock edges count, and which event returns the counter to zero. There are two kinds of count source. The first is a tap of a free-running internal divider, at divide-by 1, 4, 16 or 64. The second is one of four external clock pins. External pins are synchronised into the system clock domain and then pass through an edge detector, which turns them into single-cycle count enables.

The counter can be cleared in two ways. The first is a match or capture strobe from one of four neighbouring general registers, called A, B, C and D. The second is a synchronous-clear broadcast from other channels. When register C or D works as a buffer, its strobe cannot clear the counter. When this channel clears from one of its own register events and synchronous operation is enabled, it broadcasts a one-cycle request to other channels.

Top module: `tmr_cnt_ctrl`

## Requirements
- R1: After reset, the counter is 0x0000, the control register reads 0x00, and the overflow and synchronous-clear outputs are 0.
- R2: A write loads all 8 control bits on the next clock edge, and `cfg_o` returns the written value.
- R3: Control bits 2:0 select the count source. Codes 000, 001, 010 and 011 select the internal divider at divide-by 1, 4, 16 and 64. The counter advances by exactly one per selected tick.
- R4: Source codes 100, 101, 110 and 111 select `ext_clk_i[0]`, `[1]`, `[2]` and `[3]`. A pin level driven before clock edge k counts at edge k+2. The pins that are not selected have no effect.
- R5: Control bits 4:3 select the edge for external sources. Code 00 counts rising edges, 01 counts falling edges, and 10 or 11 count both edges. Internal sources ignore this field.
- R6: Control bits 7:5 select the clear source. 001 clears on `evt_i[0]` (A), 010 on `evt_i[1]` (B), 101 on `evt_i[2]` (C) and 110 on `evt_i[3]` (D). Codes 000 and 100 never clear. Strobes that are not selected have no effect.
- R7: When `buf_cd_i[0]` is set, code 101 never clears. When `buf_cd_i[1]` is set, code 110 never clears. Each flag leaves the other register's clear path intact.
- R8: Codes 011 and 111 clear on `sync_clr_i`, but only while `sync_en_i` is 1.
- R9: A clear loads 0x0000 on the next edge and takes priority over an increment in the same cycle.
- R10: `sync_clr_o` is high in the same cycle as a clear caused by this channel's own register event, but only while `sync_en_i` is 1. An incoming synchronous clear is not echoed on it.
- R11: An increment from 0xFFFF wraps the counter to 0x0000. `ovf_o` is then high for exactly the one following cycle.
- R12: The divider runs freely from reset, whatever the select field or counter clears do. With divide-by-N selected, any run of k·N clocks after a clear yields exactly k counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_o | output | 8 | Control register contents |
| ext_clk_i | input | 4 | External clock pins 0..3 |
| evt_i | input | 4 | Match/capture strobes, bit 0 = A .. bit 3 = D |
| buf_cd_i | input | 2 | Buffer mode, bit 0 = C, bit 1 = D |
| sync_en_i | input | 1 | Synchronous operation enable for this channel |
| sync_clr_i | input | 1 | Synchronous clear from other channels |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |
| sync_clr_o | output | 1 | Synchronous clear request to other channels |

## Verification
The bench uses the default parameters: a 16-bit counter, divider taps spaced by two bits (divide-by 1, 4, 16, 64), and two synchroniser stages. At these values, a complete wrap at divide-by-1 takes only 65,536 cycles, so the 0xFFFF-to-0x0000 transition and the overflow pulse are exercised for real rather than preloaded. The two-stage synchroniser fixes the external-pin latency at two edges, and the bench checks that latency cycle by cycle.

// File: rtl/tmr_cnt_pkg.sv
`timescale 1ns/1ps
package tmr_cnt_pkg;
  localparam int CFG_W  = 8;
  localparam int N_EXT  = 4;
  localparam int N_TAPS = 4;
  localparam int N_EVT  = 4;

  typedef struct packed {
    logic [2:0] clr_sel;
    logic [1:0] edge_sel;
    logic [2:0] src_sel;
  } cfg_t;

  localparam logic [2:0] CLR_A = 3'b001;
  localparam logic [2:0] CLR_B = 3'b010;
  localparam logic [2:0] CLR_C = 3'b101;
  localparam logic [2:0] CLR_D = 3'b110;

  localparam logic [1:0] EDGE_RISE = 2'b00;
  localparam logic [1:0] EDGE_FALL = 2'b01;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import tmr_cnt_pkg::*;
#(
  parameter int TAP_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tick_o
);
  localparam int PS_W = TAP_SHIFT * (N_TAPS - 1);

  logic [PS_W-1:0] ps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ps_q <= '0;
    else         ps_q <= ps_q + PS_W'(1);
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    if (i == 0) begin : g_div1
      assign tick_o[i] = 1'b1;
    end else begin : g_divn
      assign tick_o[i] = &ps_q[i*TAP_SHIFT-1:0];

      a_r12_tap_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[i] |=> !tick_o[i]);
    end
  end
endmodule

// File: rtl/tmr_ext_edge.sv
`timescale 1ns/1ps
module tmr_ext_edge
  import tmr_cnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EXT-1:0] pin_i,
  output logic [N_EXT-1:0] rise_o,
  output logic [N_EXT-1:0] fall_o
);
  for (genvar p = 0; p < N_EXT; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i[p]};
        prev_q <= sync_q[SYNC_STAGES-1];
      end
    end

    assign rise_o[p] =  sync_q[SYNC_STAGES-1] & ~prev_q;
    assign fall_o[p] = ~sync_q[SYNC_STAGES-1] &  prev_q;

    a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[p] |=> !rise_o[p]);
    a_r5_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[p] |=> !fall_o[p]);
  end
endmodule

// File: rtl/tmr_clr_sel.sv
`timescale 1ns/1ps
module tmr_clr_sel
  import tmr_cnt_pkg::*;
(
  input  logic [2:0]       clr_sel_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [1:0]       buf_cd_i,
  input  logic             sync_en_i,
  input  logic             sync_clr_i,
  output logic             own_clr_o,
  output logic             clr_o
);
  logic sync_hit;

  always_comb begin
    unique case (clr_sel_i)
      CLR_A:   own_clr_o = evt_i[0];
      CLR_B:   own_clr_o = evt_i[1];
      CLR_C:   own_clr_o = evt_i[2] & ~buf_cd_i[0];  // buffer mode blocks C
      CLR_D:   own_clr_o = evt_i[3] & ~buf_cd_i[1];  // buffer mode blocks D
      default: own_clr_o = 1'b0;
    endcase
  end

  // 011 and 111 both mean "follow the other channels"
  assign sync_hit = (clr_sel_i[1:0] == 2'b11) & sync_en_i & sync_clr_i;
  assign clr_o    = own_clr_o | sync_hit;
endmodule

// File: rtl/tmr_cnt_ctrl.sv
`timescale 1ns/1ps
module tmr_cnt_ctrl
  import tmr_cnt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int TAP_SHIFT   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  input  logic [N_EXT-1:0] ext_clk_i,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [1:0]       buf_cd_i,
  input  logic             sync_en_i,
  input  logic             sync_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             sync_clr_o
);
  cfg_t              cfg_q;
  logic [N_TAPS-1:0] tick;
  logic [N_EXT-1:0]  rise, fall;
  logic              own_clr, clr;
  logic              ext_hit, inc, wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  tmr_prescaler #(.TAP_SHIFT(TAP_SHIFT)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  tmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_clk_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_clr_sel u_clr (
    .clr_sel_i  (cfg_q.clr_sel),
    .evt_i      (evt_i),
    .buf_cd_i   (buf_cd_i),
    .sync_en_i  (sync_en_i),
    .sync_clr_i (sync_clr_i),
    .own_clr_o  (own_clr),
    .clr_o      (clr)
  );

  always_comb begin
    unique case (cfg_q.edge_sel)
      EDGE_RISE: ext_hit = rise[cfg_q.src_sel[1:0]];
      EDGE_FALL: ext_hit = fall[cfg_q.src_sel[1:0]];
      default:   ext_hit = rise[cfg_q.src_sel[1:0]] | fall[cfg_q.src_sel[1:0]];
    endcase
  end

  assign inc  = cfg_q.src_sel[2] ? ext_hit : tick[cfg_q.src_sel[1:0]];
  assign wrap = inc & (&cnt_q) & ~clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (clr)      cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + CNT_W'(1);
      ovf_q <= wrap;
    end
  end

  assign cfg_o      = cfg_q;
  assign cnt_o      = cnt_q;
  assign ovf_o      = ovf_q;
  assign sync_clr_o = own_clr & sync_en_i;

  a_r9_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> cnt_q == '0);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && inc) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr && !inc) |=> $stable(cnt_q));
  a_r11_ovf_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cnt_q == '0);
  a_r11_ovf_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
  a_r7_buf_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_cd_i[0] && cfg_q.clr_sel == CLR_C) |-> !clr);
  a_r7_buf_d: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_cd_i[1] && cfg_q.clr_sel == CLR_D) |-> !clr);
  a_r8_sync_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_en_i && cfg_q.clr_sel[1:0] == 2'b11) |-> !clr);
  a_r10_req_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_o |-> clr);
endmodule

// File: tb/tmr_cnt_ctrl_bench.sv
`timescale 1ns/1ps
module tmr_cnt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_o;
  logic [3:0]  ext_clk = '0;
  logic [3:0]  evt = '0;
  logic [1:0]  buf_cd = '0;
  logic        sync_en = 1'b0;
  logic        sync_clr_in = 1'b0;
  logic [15:0] cnt_o;
  logic        ovf_o;
  logic        sync_clr_o;

  always #2.5 clk = ~clk;

  tmr_cnt_ctrl u_tmr_cnt_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_o       (cfg_o),
    .ext_clk_i   (ext_clk),
    .evt_i       (evt),
    .buf_cd_i    (buf_cd),
    .sync_en_i   (sync_en),
    .sync_clr_i  (sync_clr_in),
    .cnt_o       (cnt_o),
    .ovf_o       (ovf_o),
    .sync_clr_o  (sync_clr_o)
  );

  // sel: 0 counter, 1 overflow, 2 sync request, 3 control register
  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t sb_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  function automatic int observe(input int sel);
    case (sel)
      0:       return int'(cnt_o);
      1:       return int'(ovf_o);
      2:       return int'(sync_clr_o);
      default: return int'(cfg_o);
    endcase
  endfunction

  task automatic expect_val(input string req, input int sel, input int exp);
    item_t it;
    it.req = req;
    it.sel = sel;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      int    act;
      wait (sb_q.size() != 0);
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s: sel %0d actual %0h expected %0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    step(1);
    cfg_we    = 1'b0;
    expect_val("R2", 3, int'(v));
  endtask

  task automatic evt_pulse(input logic [3:0] m, input int exp_req);
    evt = m;
    #1 expect_val("R10", 2, exp_req);
    step(1);
    evt = '0;
  endtask

  task automatic pin_pulse(input int p);
    ext_clk[p] = 1'b1;
    step(3);
    ext_clk[p] = 1'b0;
    step(3);
  endtask

  task automatic clr_case(input logic [2:0] code, input int hit);
    int v;
    wr({code, 5'b00_100});
    pin_pulse(0);
    pin_pulse(0);
    v = int'(cnt_o);
    if (hit < 0) begin
      evt_pulse(4'hF, 0);
      expect_val("R6", 0, v);
    end else begin
      evt_pulse(~(4'b1 << hit), 0);
      expect_val("R6", 0, v);
      evt_pulse(4'b1 << hit, 0);
      expect_val("R6", 0, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : driver
    int v;
    step(2);
    expect_val("R1", 0, 0);
    expect_val("R1", 1, 0);
    expect_val("R1", 2, 0);
    expect_val("R1", 3, 0);
    rst_ni = 1'b1;

    // internal divide-by-1; clear beats increment
    wr(8'b001_00_000);
    evt_pulse(4'b0001, 0);
    expect_val("R9", 0, 0);
    step(10);
    expect_val("R3", 0, 10);

    // edge field has no effect on internal source
    wr(8'b001_01_000);
    evt_pulse(4'b0001, 0);
    step(7);
    expect_val("R5", 0, 7);

    // divider taps, free-running
    wr(8'b001_00_001);
    evt_pulse(4'b0001, 0);
    step(64);
    expect_val("R12", 0, 16);
    wr(8'b001_00_010);
    evt_pulse(4'b0001, 0);
    step(64);
    expect_val("R12", 0, 4);
    wr(8'b001_00_011);
    evt_pulse(4'b0001, 0);
    step(128);
    expect_val("R3", 0, 2);

    // external pin 0, rising, two-edge latency
    wr(8'b001_00_100);
    evt_pulse(4'b0001, 0);
    expect_val("R9", 0, 0);
    ext_clk[0] = 1'b1;
    step(2);
    expect_val("R4", 0, 0);
    step(1);
    expect_val("R4", 0, 1);
    ext_clk[0] = 1'b0;
    step(3);
    expect_val("R5", 0, 1);
    pin_pulse(0);
    pin_pulse(0);
    expect_val("R5", 0, 3);
    pin_pulse(1);
    expect_val("R4", 0, 3);

    // pin 1 falling
    wr(8'b001_01_101);
    evt_pulse(4'b0001, 0);
    pin_pulse(1);
    pin_pulse(1);
    pin_pulse(1);
    expect_val("R5", 0, 3);
    pin_pulse(0);
    expect_val("R4", 0, 3);

    // pin 2 both edges (10), pin 3 both edges (11)
    wr(8'b001_10_110);
    evt_pulse(4'b0001, 0);
    pin_pulse(2);
    pin_pulse(2);
    pin_pulse(2);
    expect_val("R5", 0, 6);
    wr(8'b001_11_111);
    evt_pulse(4'b0001, 0);
    pin_pulse(3);
    pin_pulse(3);
    expect_val("R5", 0, 4);

    // clear source decode
    clr_case(3'b001, 0);
    clr_case(3'b010, 1);
    clr_case(3'b101, 2);
    clr_case(3'b110, 3);
    clr_case(3'b000, -1);
    clr_case(3'b100, -1);

    // buffer mode on C and D
    buf_cd = 2'b01;
    wr(8'b101_00_100);
    pin_pulse(0);
    v = int'(cnt_o);
    evt_pulse(4'b0100, 0);
    expect_val("R7", 0, v);
    wr(8'b110_00_100);
    pin_pulse(0);
    evt_pulse(4'b1000, 0);
    expect_val("R7", 0, 0);
    buf_cd = 2'b10;
    pin_pulse(0);
    pin_pulse(0);
    v = int'(cnt_o);
    evt_pulse(4'b1000, 0);
    expect_val("R7", 0, v);
    buf_cd = 2'b00;

    // incoming synchronous clear
    wr(8'b011_00_100);
    pin_pulse(0);
    v = int'(cnt_o);
    sync_clr_in = 1'b1;
    step(1);
    sync_clr_in = 1'b0;
    expect_val("R8", 0, v);
    sync_en = 1'b1;
    sync_clr_in = 1'b1;
    #1 expect_val("R10", 2, 0);
    step(1);
    sync_clr_in = 1'b0;
    expect_val("R8", 0, 0);
    wr(8'b111_00_100);
    pin_pulse(0);
    sync_clr_in = 1'b1;
    step(1);
    sync_clr_in = 1'b0;
    expect_val("R8", 0, 0);

    // outgoing request
    wr(8'b010_00_100);
    pin_pulse(0);
    evt_pulse(4'b0010, 1);
    expect_val("R10", 0, 0);
    evt_pulse(4'b0001, 0);
    sync_en = 1'b0;
    evt_pulse(4'b0010, 0);

    // full wrap at divide-by-1
    wr(8'b001_00_000);
    evt_pulse(4'b0001, 0);
    step(65535);
    expect_val("R11", 0, 16'hFFFF);
    expect_val("R11", 1, 0);
    step(1);
    expect_val("R11", 0, 0);
    expect_val("R11", 1, 1);
    step(1);
    expect_val("R11", 0, 1);
    expect_val("R11", 1, 0);

    wait (sb_q.size() == 0);
    #1;
    finish_run();
  end
endmodule